// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register and interrupt front end of a simple serial port. A CPU reaches it over a single-cycle, word-addressed 32-bit register bus. A write to the data-out register loads one byte onto an outgoing byte stream that uses valid/ready handshaking. Bytes that arrive on an incoming valid/ready byte stream are captured into a status/data word. The CPU reads that word at one of two aliased offsets, and only one of the two consumes the data-available flag.

Two events raise interrupt sources: an accepted transmit byte raises bit 0, and a received byte raises bit 3. A mask selects which raw sources drive the single interrupt line. The CPU clears raw sources by writing ones to an acknowledge register, which acts once and never holds a value. Receive flow control holds new bytes off while a receive interrupt is pending, unless the receive-enable control bit is set.

Top module: `serial_regs`

## Requirements
- R1: After reset, the status/data word reads 0x0140_0000 (bit 24 transmitter-ready and bit 22 transmitter-idle set, nothing else). The raw interrupt register reads 0, `irq_o` and `tx_valid_o` are low, and `rx_ready_o` is high.
- R2: The word addresses are transmit control 0, DMA enable 1, receive control 2 and mask 11. These four registers read back exactly what was last written. Word addresses 3–6, 10 and 15 read zero, and writes to them have no effect.
- R3: A write to data out (word 7) that is accepted drives `tx_valid_o` high from the next cycle, with `tx_data_o` equal to `wdata_i[7:0]`. It also stores the full 32-bit value for read-back at word 7 and sets raw interrupt bit 0.
- R4: While a byte is pending, `tx_valid_o` and `tx_data_o` stay stable until `tx_ready_i` is sampled high. During that time status bits 22 and 24 read 0. Both bits return to 1 once the handshake completes.
- R5: A data-out write made while `tx_valid_o` is high is dropped. The pending byte, the stored data-out value and raw bit 0 do not change.
- R6: A byte is accepted when `rx_valid_i` and `rx_ready_o` are both high. The byte then replaces status bits [7:0], and the cycle also sets data-available (bit 16) and raw interrupt bit 3.
- R7: Reading word 8 returns the status/data word and then clears data-available. Reading word 9 returns the same word and clears nothing.
- R8: If a byte is accepted in the same cycle as a read of word 8, data-available stays set.
- R9: `rx_ready_o` is high when receive-control bit 0 is set or raw bit 3 is clear. An incoming byte offered while `rx_ready_o` is low leaves the status word unchanged.
- R10: A write to acknowledge (word 12) clears every raw bit where the write data is 1. A set event in the same cycle wins over the clear. Word 12 always reads zero.
- R11: The masked interrupt register (word 14) reads raw AND mask. `irq_o` is high exactly when any masked bit is set. The raw register is word 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Outgoing byte taken |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Block can take an incoming byte |
| irq_o | output | 1 | Interrupt line |

## Verification
`rdata_o` depends on the address only through logic, so the bench samples it in the same cycle it drives the read, before the clock edge that applies any read side effect. Every register write, byte arrival and handshake takes effect at the next rising edge. Outputs built from that state (`tx_valid_o`, `tx_data_o`, `rx_ready_o`, `irq_o`) are therefore due one cycle after the stimulus. The bench changes inputs on falling edges and reads results on a later falling edge, so each result is sampled half a period after the edge that produced it. The simultaneous cases of R8 and R10 are driven inside a single cycle to exercise the priority rules.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  parameter int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_TXCTL = 4'd0;
  localparam logic [REG_AW-1:0] A_DMAEN = 4'd1;
  localparam logic [REG_AW-1:0] A_RXCTL = 4'd2;
  localparam logic [REG_AW-1:0] A_DOUT  = 4'd7;
  localparam logic [REG_AW-1:0] A_STCLR = 4'd8;
  localparam logic [REG_AW-1:0] A_STPEK = 4'd9;
  localparam logic [REG_AW-1:0] A_MASK  = 4'd11;
  localparam logic [REG_AW-1:0] A_ACK   = 4'd12;
  localparam logic [REG_AW-1:0] A_RAW   = 4'd13;
  localparam logic [REG_AW-1:0] A_MSKD  = 4'd14;

  localparam int unsigned ST_DAV  = 16;
  localparam int unsigned ST_IDLE = 22;
  localparam int unsigned ST_RDY  = 24;

  localparam int unsigned IRQ_TX = 0;
  localparam int unsigned IRQ_RX = 3;
endpackage

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic              accept_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  assign accept_o = load_i && !tx_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else if (accept_o) begin
      tx_valid_o <= 1'b1;
      tx_data_o  <= load_data_i;
    end else if (tx_valid_o && tx_ready_i) begin
      tx_valid_o <= 1'b0;
    end
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !tx_valid_o) |=> (tx_valid_o && tx_data_o == $past(load_data_i)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pend_i,
  input  logic              clr_rd_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              take_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              dav_o
);
  assign rx_ready_o = en_i || !pend_i;
  assign take_o     = rx_valid_i && rx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      dav_o  <= 1'b0;
    end else if (take_o) begin
      // arrival has priority over a clearing read
      byte_o <= rx_data_i;
      dav_o  <= 1'b1;
    end else if (clr_rd_i) begin
      dav_o  <= 1'b0;
    end
  end

  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (dav_o && byte_o == $past(rx_data_i)));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rd_i && !take_o) |=> !dav_o);

  a_r8_arrival_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rd_i && take_o) |=> dav_o);

  a_r9_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_o && !clr_rd_i) |=> ($stable(byte_o) && $stable(dav_o)));
endmodule

// File: rtl/sreg_irq.sv
module sreg_irq #(
  parameter int unsigned IRQ_W  = 8,
  parameter int unsigned TX_BIT = 0,
  parameter int unsigned RX_BIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_set_i,
  input  logic             rx_set_i,
  input  logic             ack_we_i,
  input  logic [IRQ_W-1:0] ack_bits_i,
  input  logic [IRQ_W-1:0] mask_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[TX_BIT] = tx_set_i;
    set_vec[RX_BIT] = rx_set_i;
    clr_vec         = ack_we_i ? ack_bits_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= (raw_o & ~clr_vec) | set_vec;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  a_r10_ack_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && ack_bits_i[RX_BIT] && !rx_set_i) |=> !raw_o[RX_BIT]);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> raw_o[RX_BIT]);

  a_r3_tx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> raw_o[TX_BIT]);
endmodule

// File: rtl/serial_regs.sv
module serial_regs
  import serial_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              irq_o
);
  localparam int unsigned IRQ_PAD = DATA_W - IRQ_W;

  logic [DATA_W-1:0] txctl_q, dmaen_q, rxctl_q, mask_q, dout_q;
  logic [DATA_W-1:0] status;
  logic              wr_dout, tx_acc, clr_rd, rx_take, dav;
  logic [BYTE_W-1:0] rx_byte;
  logic [IRQ_W-1:0]  raw, masked;

  assign wr_dout = we_i && (addr_i == A_DOUT);
  assign clr_rd  = re_i && (addr_i == A_STCLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txctl_q <= '0;
      dmaen_q <= '0;
      rxctl_q <= '0;
      mask_q  <= '0;
      dout_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_TXCTL: txctl_q <= wdata_i;
        A_DMAEN: dmaen_q <= wdata_i;
        A_RXCTL: rxctl_q <= wdata_i;
        A_MASK:  mask_q  <= wdata_i;
        A_DOUT:  if (tx_acc) dout_q <= wdata_i;
        default: ;
      endcase
    end
  end

  sreg_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wr_dout),
    .load_data_i (wdata_i[BYTE_W-1:0]),
    .accept_o    (tx_acc),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i)
  );

  sreg_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rxctl_q[0]),
    .pend_i     (raw[IRQ_RX]),
    .clr_rd_i   (clr_rd),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_ready_o (rx_ready_o),
    .take_o     (rx_take),
    .byte_o     (rx_byte),
    .dav_o      (dav)
  );

  sreg_irq #(.IRQ_W(IRQ_W), .TX_BIT(IRQ_TX), .RX_BIT(IRQ_RX)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_set_i   (tx_acc),
    .rx_set_i   (rx_take),
    .ack_we_i   (we_i && (addr_i == A_ACK)),
    .ack_bits_i (wdata_i[IRQ_W-1:0]),
    .mask_i     (mask_q[IRQ_W-1:0]),
    .raw_o      (raw),
    .masked_o   (masked),
    .irq_o      (irq_o)
  );

  always_comb begin
    status               = '0;
    status[BYTE_W-1:0]   = rx_byte;
    status[ST_DAV]       = dav;
    status[ST_IDLE]      = !tx_valid_o;
    status[ST_RDY]       = !tx_valid_o;
  end

  always_comb begin
    unique case (addr_i)
      A_TXCTL:          rdata_o = txctl_q;
      A_DMAEN:          rdata_o = dmaen_q;
      A_RXCTL:          rdata_o = rxctl_q;
      A_DOUT:           rdata_o = dout_q;
      A_STCLR, A_STPEK: rdata_o = status;
      A_MASK:           rdata_o = mask_q;
      A_RAW:            rdata_o = {{IRQ_PAD{1'b0}}, raw};
      A_MSKD:           rdata_o = {{IRQ_PAD{1'b0}}, masked};
      default:          rdata_o = '0;
    endcase
  end

  a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dout && tx_valid_o) |=> $stable(dout_q));

  a_r7_peek_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_STPEK && dav) |=> dav);

  a_r4_ready_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_valid_o) |-> (status[ST_RDY] && status[ST_IDLE]));
endmodule

// File: tb/tb_serial_regs.sv
`timescale 1ns/1ps
module tb_serial_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  serial_regs dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    re_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd9, d);  chk("R1 status", d, 32'h0140_0000);
    rd(4'd13, d); chk("R1 raw", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 tx_valid", tx_valid_o, 0);
    chk("R1 rx_ready", rx_ready_o, 1);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, d);  chk("R2 txctl", d, 32'hDEAD_BEEF);
    wr(4'd1, 32'h1234_5678); rd(4'd1, d);  chk("R2 dmaen", d, 32'h1234_5678);
    wr(4'd2, 32'hA5A5_0000); rd(4'd2, d);  chk("R2 rxctl", d, 32'hA5A5_0000);
    wr(4'd11, 32'hF0F0_0000); rd(4'd11, d); chk("R2 mask", d, 32'hF0F0_0000);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d);  chk("R2 unmapped 3", d, 0);
    wr(4'd10, 32'hFFFF_FFFF); rd(4'd10, d); chk("R2 unmapped 10", d, 0);
    rd(4'd0, d); chk("R2 txctl kept", d, 32'hDEAD_BEEF);
    rd(4'd9, d); chk("R2 status kept", d, 32'h0140_0000);
    wr(4'd2, 0); wr(4'd11, 0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    tx_ready_i = 1'b0;
    wr(4'd7, 32'hABCD_125A);
    chk("R3 tx_valid", tx_valid_o, 1);
    chk("R3 tx_data", tx_data_o, 32'h5A);
    rd(4'd7, d);  chk("R3 dout stored", d, 32'hABCD_125A);
    rd(4'd13, d); chk("R3 raw bit0", d, 32'h1);
    rd(4'd9, d);  chk("R4 busy flags", d & 32'h0140_0000, 0);
    wr(4'd12, 32'h1); // clear bit0 to see R5 drop
    wr(4'd7, 32'h0000_0077);
    chk("R5 byte kept", tx_data_o, 32'h5A);
    chk("R4 valid held", tx_valid_o, 1);
    rd(4'd7, d);  chk("R5 dout kept", d, 32'hABCD_125A);
    rd(4'd13, d); chk("R5 raw not set", d, 0);
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(negedge clk_i); tx_ready_i = 1'b0;
    chk("R4 released", tx_valid_o, 0);
    rd(4'd9, d); chk("R4 idle flags", d & 32'h0140_0000, 32'h0140_0000);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(4'd7, 32'h33);
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(negedge clk_i); tx_ready_i = 1'b0;
    rd(4'd13, d); chk("R3 raw set again", d, 1);
    rd(4'd12, d); chk("R10 ack reads 0", d, 0);
    wr(4'd12, 32'h1);
    rd(4'd13, d); chk("R10 ack clears", d, 0);
    rd(4'd12, d); chk("R10 ack reads 0 after", d, 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    push(8'hC3);
    rd(4'd9, d);  chk("R6 captured", d, 32'h0141_00C3);
    rd(4'd13, d); chk("R6 raw bit3", d, 32'h8);
    rd(4'd9, d);  chk("R7 peek keeps dav", d, 32'h0141_00C3);
    rd(4'd8, d);  chk("R7 clr read value", d, 32'h0141_00C3);
    rd(4'd9, d);  chk("R7 dav cleared", d, 32'h0140_00C3);
  endtask

  task automatic t_flow();
    logic [31:0] d;
    chk("R9 ready low", rx_ready_o, 0);
    push(8'h11);
    rd(4'd9, d); chk("R9 byte ignored", d, 32'h0140_00C3);
    wr(4'd2, 32'h1);
    chk("R9 ready by enable", rx_ready_o, 1);
    push(8'h22);
    rd(4'd9, d); chk("R9 accepted when enabled", d, 32'h0141_0022);
    wr(4'd2, 0);
    chk("R9 ready low again", rx_ready_o, 0);
    wr(4'd12, 32'h8);
    chk("R9 ready after ack", rx_ready_o, 1);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk_i);
    re_i = 1'b1; addr_i = 4'd8; rx_valid_i = 1'b1; rx_data_i = 8'h5E;
    @(negedge clk_i);
    re_i = 1'b0; rx_valid_i = 1'b0;
    rd(4'd9, d); chk("R8 arrival wins", d, 32'h0141_005E);
    wr(4'd2, 32'h1);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 4'd12; wdata_i = 32'h8; rx_valid_i = 1'b1; rx_data_i = 8'h6F;
    @(negedge clk_i);
    we_i = 1'b0; rx_valid_i = 1'b0;
    rd(4'd13, d); chk("R10 set beats ack", d, 32'h8);
    rd(4'd9, d);  chk("R10 byte taken", d, 32'h0141_006F);
    wr(4'd2, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    chk("R11 irq masked off", irq_o, 0);
    rd(4'd14, d); chk("R11 masked zero", d, 0);
    wr(4'd11, 32'h8);
    chk("R11 irq on", irq_o, 1);
    rd(4'd14, d); chk("R11 masked value", d, 32'h8);
    wr(4'd11, 32'h1);
    chk("R11 other mask", irq_o, 0);
    wr(4'd11, 32'h9);
    wr(4'd12, 32'h8);
    chk("R11 irq after ack", irq_o, 0);
    rd(4'd14, d); chk("R11 masked after ack", d, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_storage();
    t_tx();
    t_ack();
    t_rx();
    t_flow();
    t_race();
    t_irq();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule